// File: doc/BRIEF.md
# Synchronous Parallel-Load Serial-Out Shift Register

This block is a chain of stages that can be filled all at once from a parallel word and then drained one bit at a time toward its last stage. It runs entirely on one fast system clock. The external shift clock, the clock-inhibit line, the active-low load control, the serial input and the parallel word are all treated as plain data. They are sampled through two-flop synchronizers, and nothing outside the system clock drives a flop.

A shift happens on a rising edge of the OR of the synchronized shift clock and inhibit lines. Either line can therefore act as the clock while the other is held low. Holding either line high freezes the chain. A low load control is a level-sensitive override: while it is low, the stages follow the parallel word whatever the clock lines do. The last stage is driven out together with its complement, and every stage is visible on a wide port for checking.

Every input change reaches the stages on the third rising system clock edge after the change: two synchronizer flops and then the stage register.

Top module: `piso_gated_shreg`

## Requirements
- R1: While `load_n` is low, stage i copies `pdata[i]` for every i, whatever the levels of `sclk`, `sinh` and `sdin`. Stage 0 is the entry stage and stage WIDTH-1 is the output stage.
- R2: While `load_n` is high, `pdata` has no effect on any stage.
- R3: With `load_n` high and `sinh` low, a low-to-high change of `sclk` causes exactly one shift. Stage i+1 takes the old stage i, and stage 0 takes the `sdin` level sampled with that edge.
- R4: With `sclk` low, a low-to-high change of `sinh` also causes exactly one shift, so the two lines are interchangeable.
- R5: With `load_n` high, all stages hold their values when there is no rising edge of (`sclk` OR `sinh`). This includes `sclk` toggling while `sinh` is high.
- R6: `q_last` equals the output stage, and `q_last_n` is its complement.
- R7: Releasing `load_n` while `sclk` or `sinh` is already high causes no shift.
- R8: A synchronous active-high `rst` clears every stage and every synchronizer flop to zero.
- R9: An input change shows on the stages after the third rising `clk` edge that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low level-sensitive parallel load |
| sclk | input | 1 | External shift clock (sampled) |
| sinh | input | 1 | Clock inhibit, interchangeable with sclk (sampled) |
| sdin | input | 1 | Serial data entering stage 0 |
| pdata | input | WIDTH | Parallel load word, bit i to stage i |
| q_last | output | 1 | Output stage value |
| q_last_n | output | 1 | Complement of the output stage |
| stage_q | output | WIDTH | All stage values |

## Verification
The hardest case to reach is a stale edge when a load ends. The combined clock goes high while the load is still active, and the load is then released with the combined clock still high. The stimulus loads a new word in the same step that raises `sclk`, releases the load with `sclk` still high, and expects the word to stay unshifted until a fresh low-to-high change. Shifting by `sinh` while `sclk` is low, and `sclk` toggling while `sinh` is high, are driven as separate table rows. An eight-shift drain then checks the serial output order bit by bit.

// File: rtl/piso_pkg.sv
package piso_pkg;
    localparam int SYNC_DEPTH = 2;

    typedef struct packed {
        logic load_n;
        logic sclk;
        logic sinh;
        logic sdin;
    } piso_ctrl_t;

    localparam int CTRL_W = $bits(piso_ctrl_t);

    function automatic logic [63:0] shift_toward_out(input logic [63:0] cur, input logic din);
        return {cur[62:0], din};
    endfunction
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int W     = 1,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_flop
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[g] <= '0;
                end else begin
                    chain[g] <= (g == 0) ? din : chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[DEPTH-1];
endmodule

// File: rtl/piso_edge_detect.sv
module piso_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic clk_s,
    input  logic inh_s,
    output logic rise
);
    logic eff;
    logic eff_prev;

    assign eff  = clk_s | inh_s;
    assign rise = eff & ~eff_prev;

    // The history always tracks the current OR value, also while a load is
    // active, so a combined clock that rose under load leaves no edge behind.
    always_ff @(posedge clk) begin
        if (rst) eff_prev <= 1'b0;
        else     eff_prev <= eff;
    end

    // R3
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/piso_stage_chain.sv
module piso_stage_chain #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_act,
    input  logic             rise,
    input  logic             sdin,
    input  logic [WIDTH-1:0] pdata,
    output logic [WIDTH-1:0] stages
);
    import piso_pkg::*;

    logic [63:0] shifted;
    always_comb shifted = shift_toward_out(64'(stages), sdin);

    always_ff @(posedge clk) begin
        if (rst)           stages <= '0;
        else if (load_act) stages <= pdata;
        else if (rise)     stages <= shifted[WIDTH-1:0];
    end

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> stages == '0);
    // R1
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        load_act |=> stages == $past(pdata));
    // R3
    shift_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_act && rise) |=> stages == {$past(stages[WIDTH-2:0]), $past(sdin)});
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_act && !rise) |=> $stable(stages));
endmodule

// File: rtl/piso_gated_shreg.sv
module piso_gated_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic             sclk,
    input  logic             sinh,
    input  logic             sdin,
    input  logic [WIDTH-1:0] pdata,
    output logic             q_last,
    output logic             q_last_n,
    output logic [WIDTH-1:0] stage_q
);
    import piso_pkg::*;

    localparam int SYNC_W = CTRL_W + WIDTH;

    piso_ctrl_t       ctrl_raw, ctrl_s;
    logic [WIDTH-1:0] pdata_s;
    logic [SYNC_W-1:0] sync_out;
    logic             rise;
    logic [WIDTH-1:0] stages;

    always_comb begin
        ctrl_raw.load_n = load_n;
        ctrl_raw.sclk   = sclk;
        ctrl_raw.sinh   = sinh;
        ctrl_raw.sdin   = sdin;
    end

    piso_sync #(.W(SYNC_W), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ctrl_raw, pdata}),
        .dout (sync_out)
    );

    assign ctrl_s  = piso_ctrl_t'(sync_out[SYNC_W-1:WIDTH]);
    assign pdata_s = sync_out[WIDTH-1:0];

    piso_edge_detect u_edge (
        .clk   (clk),
        .rst   (rst),
        .clk_s (ctrl_s.sclk),
        .inh_s (ctrl_s.sinh),
        .rise  (rise)
    );

    piso_stage_chain #(.WIDTH(WIDTH)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .load_act (~ctrl_s.load_n),
        .rise     (rise),
        .sdin     (ctrl_s.sdin),
        .pdata    (pdata_s),
        .stages   (stages)
    );

    assign stage_q  = stages;
    assign q_last   = stages[WIDTH-1];
    assign q_last_n = ~stages[WIDTH-1];

    // R7
    no_stale_shift_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctrl_s.load_n) && $past(ctrl_s.sclk | ctrl_s.sinh)) |-> !rise);
endmodule

// File: tb/piso_gated_shreg_bench.sv
module piso_gated_shreg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    typedef struct packed {
        logic       ld;
        logic       ck;
        logic       ih;
        logic       sd;
        logic [7:0] pd;
        logic [7:0] ex;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5}, // R1 load
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hA5}, // R2 release, pdata ignored
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h4B}, // R3 clock rise
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h4B}, // R5 clock fall
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h96}, // R3 clock rise
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h96}, // R5
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h2D}, // R4 inhibit rise, clock low
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h2D}, // R5 clock rise under inhibit
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h2D}, // R5
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h2D}, // R5 inhibit fall
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h5A}, // R3
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h5A}, // R5
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'h3C, 8'h3C}, // R1 load mid-sequence
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h3C}, // R7 release with clock high
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h3C}, // R5
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h79}  // R3
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_n = 1'b0;
    logic         sclk = 1'b0;
    logic         sinh = 1'b0;
    logic         sdin = 1'b0;
    logic [W-1:0] pdata = '0;
    logic         q_last, q_last_n;
    logic [W-1:0] stage_q;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    piso_gated_shreg #(.WIDTH(W)) u_piso_gated_shreg (
        .clk(clk), .rst(rst), .load_n(load_n), .sclk(sclk), .sinh(sinh),
        .sdin(sdin), .pdata(pdata), .q_last(q_last), .q_last_n(q_last_n),
        .stage_q(stage_q)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R9: three edges to reach the stages; one spare edge before sampling
    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic check_outs(input string req, input logic [W-1:0] exp);
        check(req, stage_q, exp);
        check("R6 q_last", {7'd0, q_last}, {7'd0, exp[W-1]});
        check("R6 q_last_n", {7'd0, q_last_n}, {7'd0, ~exp[W-1]});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] exp;
        logic [7:0]   pat;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        check_outs("R8 reset", 8'h00);

        for (int i = 0; i < NV; i++) begin
            load_n = VECS[i].ld;
            sclk   = VECS[i].ck;
            sinh   = VECS[i].ih;
            sdin   = VECS[i].sd;
            pdata  = VECS[i].pd;
            settle();
            check_outs($sformatf("R1-5/R7 vec%0d", i), VECS[i].ex);
        end

        // R9 latency: change at step, not visible after two edges, visible after three
        sclk = 1'b0; settle();
        load_n = 1'b0; pdata = 8'hE7;
        @(posedge clk); @(posedge clk); #1;
        check_outs("R9 early", 8'h79);
        @(posedge clk); #1;
        check_outs("R9 third edge", 8'hE7);

        // R3 drain: load 96, shift eight times, watch serial order
        pdata = 8'h96; settle();
        load_n = 1'b1; settle();
        exp = 8'h96;
        pat = 8'hD2;
        for (int k = 0; k < 8; k++) begin
            check("R6 serial order", {7'd0, q_last}, {7'd0, exp[W-1]});
            sdin = pat[k];
            sclk = 1'b1; settle();
            exp = {exp[W-2:0], pat[k]};
            sclk = 1'b0; settle();
        end
        check_outs("R3 drain final", exp);

        // R8 reset mid-operation
        rst = 1'b1; settle();
        rst = 1'b0; #1;
        check_outs("R8 reset mid-run", 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule